// File: doc/BRIEF.md
# Chip-Select Cycle Termination Controller

This block owns one chip-select window on an external bus and decides when each beat of a transfer ends. A sequencer asks for a read or write of one to many beats. The block then lowers its active-low chip select and keeps it low across every beat. It releases the chip select one cycle after the beat that ends the transfer. For a write, it keeps the data drivers on for one more cycle after that.

Each beat ends in one of two ways:

- **External acknowledge.** The external device raises its acknowledge.
- **Auto-acknowledge.** When this mode is configured, the block counts a programmed number of wait states and then generates the acknowledge itself.

With auto-acknowledge on, an external acknowledge that arrives before the count runs out still ends the beat at once. The acknowledge input is registered once. An acknowledge counts only if it was sampled while the chip select was low. A configuration valid bit gates the whole window: while it is clear, requests are dropped.

Top module: `cs_term_ctrl`

## Requirements
- R1: With auto-acknowledge off (latched `cfg_auto_ack`=0), a beat ends only through the external acknowledge. An `ext_ack` high in beat cycle k (cycle 0 is the first cycle the chip select is low for that beat) ends the beat in cycle k+1, with `beat_done` high in that cycle.
- R2: With auto-acknowledge on and wait count W and no external acknowledge, a beat ends in its cycle W, so it lasts W+1 cycles. W=0 ends the beat in its first cycle.
- R3: With auto-acknowledge on, an `ext_ack` high in beat cycle k with k+1 < W ends the beat in cycle k+1. When k+1 equals W, the beat ends once, in cycle W.
- R4: `rd_latch` is high exactly in the cycle a read beat ends and is never high during a write.
- R5: `cs_n` goes low the cycle after an accepted request and stays low between beats. It goes high in the cycle after the beat that raised `xfer_done`.
- R6: For a write, `wr_oe` is high from the first beat cycle through the one cycle after `cs_n` returns high, and low afterwards. For a read, `wr_oe` stays low.
- R7: `ext_ack` is sampled only while `cs_n` is low. An acknowledge high while `cs_n` is high, or high in the cycle a beat ends, has no effect on any later beat.
- R8: A `req_start` pulse while `cfg_valid` is 0 is ignored: `cs_n` stays high and no beat starts.
- R9: The auto-acknowledge enable and wait count are latched when a request is accepted. The wait counter reloads from the latched count at the start of every beat, so each beat of a burst gets the full count, whatever the configuration inputs do meanwhile.
- R10: `beat_done` pulses once per beat. `xfer_done` pulses together with the `beat_done` of beat number `req_beats_m1`+1 (the last one).
- R11: Out of reset (`rst` synchronous, active high), `cs_n` is 1 and `rd_latch`, `wr_oe`, `beat_done` and `xfer_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Window enabled; requests are ignored while 0 |
| cfg_auto_ack | input | 1 | Generate the acknowledge internally after the wait count |
| cfg_wait | input | WAIT_W | Wait states per beat in auto-acknowledge mode |
| req_start | input | 1 | Start a transfer (accepted only when idle and valid) |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_beats_m1 | input | BEAT_W | Number of beats minus one |
| ext_ack | input | 1 | External transfer acknowledge, active high |
| cs_n | output | 1 | Chip select, active low |
| rd_latch | output | 1 | Read data capture strobe |
| wr_oe | output | 1 | Write data output enable |
| beat_done | output | 1 | One-cycle pulse when a beat ends |
| xfer_done | output | 1 | One-cycle pulse when the last beat ends |

## Verification
Wait-state expiry and a registered external acknowledge can arrive in the same beat cycle. The bench provokes this by pulsing `ext_ack` in cycle W-1 with auto-acknowledge on, so that both terminations meet in cycle W. It then checks that exactly one `beat_done` appears in that cycle. It also checks that the following beat still runs its full W+1 cycles, because a doubled acknowledge would show up as a truncated next beat. A held acknowledge that overlaps a beat's end cycle is judged the same way, by watching the start of the next beat.

// File: rtl/cs_term_pkg.sv
package cs_term_pkg;

    // Bus window phase: idle, inside a beat (chip select low), write tail
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_TAIL = 2'd2
    } cyc_state_e;

    // Per-transfer mode captured at request acceptance
    typedef struct packed {
        logic auto_ack;
        logic write;
    } xfer_mode_t;

    // A beat terminates on a recognised acknowledge or on wait expiry in auto mode
    function automatic logic beat_term(input logic auto_en,
                                       input logic expired,
                                       input logic ack_seen);
        return ack_seen | (auto_en & expired);
    endfunction

    // Phase entered after the final beat: writes keep data for one more cycle
    function automatic cyc_state_e after_last(input logic is_write);
        return is_write ? ST_TAIL : ST_IDLE;
    endfunction

endpackage

// File: rtl/cs_ack_sampler.sv
module cs_ack_sampler (
    input  logic clk,
    input  logic rst,
    input  logic ext_ack,
    input  logic cs_active,
    input  logic discard,
    output logic ack_q
);

    // Single register stage; samples only inside the window and drops
    // an acknowledge seen in the cycle the current beat already ends.
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= ext_ack & cs_active & ~discard;
        end
    end

    // R7: nothing sampled while the chip select is high
    p_ack_gated_r7: assert property (@(posedge clk) disable iff (rst)
        !cs_active |=> !ack_q);

endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer #(
    parameter int unsigned WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expired
);

    localparam logic [WAIT_W-1:0] CNT_ZERO = '0;
    localparam logic [WAIT_W-1:0] CNT_ONE  = WAIT_W'(1);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ZERO;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != CNT_ZERO) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign expired = (cnt_q == CNT_ZERO);

endmodule

// File: rtl/cs_beat_fsm.sv
module cs_beat_fsm
    import cs_term_pkg::*;
#(
    parameter int unsigned BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_auto_ack,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [BEAT_W-1:0] req_beats_m1,
    input  logic              ack_q,
    input  logic              expired,
    output cyc_state_e        state,
    output xfer_mode_t        mode,
    output logic              beat_end,
    output logic              last_beat,
    output logic              timer_load
);

    localparam logic [BEAT_W-1:0] LEFT_ZERO = '0;
    localparam logic [BEAT_W-1:0] LEFT_ONE  = BEAT_W'(1);

    cyc_state_e        state_q, state_d;
    xfer_mode_t        mode_q;
    logic [BEAT_W-1:0] left_q;
    logic              accept;

    assign accept    = (state_q == ST_IDLE) & req_start & cfg_valid;
    assign last_beat = (left_q == LEFT_ZERO);
    assign beat_end  = (state_q == ST_BEAT) &
                       beat_term(mode_q.auto_ack, expired, ack_q);
    assign timer_load = accept | (beat_end & ~last_beat);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = ST_BEAT;
            ST_BEAT: if (beat_end && last_beat) state_d = after_last(mode_q.write);
            ST_TAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            left_q  <= LEFT_ZERO;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mode_q.auto_ack <= cfg_auto_ack;
                mode_q.write    <= req_write;
                left_q          <= req_beats_m1;
            end else if (beat_end && !last_beat) begin
                left_q <= left_q - LEFT_ONE;
            end
        end
    end

    assign state = state_q;
    assign mode  = mode_q;

    // R1: without auto mode only a recognised acknowledge can end a beat
    p_noauto_ack_r1: assert property (@(posedge clk) disable iff (rst)
        (beat_end && !mode_q.auto_ack) |-> ack_q);

    // R9: latched mode cannot change while the window is open
    p_mode_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BEAT) |=> $stable(mode_q));

endmodule

// File: rtl/cs_term_ctrl.sv
module cs_term_ctrl
    import cs_term_pkg::*;
#(
    parameter int unsigned WAIT_W = 4,
    parameter int unsigned BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_valid,
    input  logic              cfg_auto_ack,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [BEAT_W-1:0] req_beats_m1,
    input  logic              ext_ack,
    output logic              cs_n,
    output logic              rd_latch,
    output logic              wr_oe,
    output logic              beat_done,
    output logic              xfer_done
);

    cyc_state_e        state;
    xfer_mode_t        mode;
    logic              beat_end;
    logic              last_beat;
    logic              timer_load;
    logic              expired;
    logic              ack_q;
    logic              in_beat;
    logic [WAIT_W-1:0] wait_lat_q;

    assign in_beat = (state == ST_BEAT);

    // Wait count is latched with the request so every beat reloads the same value
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_lat_q <= '0;
        end else if (state == ST_IDLE && req_start && cfg_valid) begin
            wait_lat_q <= cfg_wait;
        end
    end

    cs_ack_sampler u_ack (
        .clk       (clk),
        .rst       (rst),
        .ext_ack   (ext_ack),
        .cs_active (in_beat),
        .discard   (beat_end),
        .ack_q     (ack_q)
    );

    cs_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val ((state == ST_IDLE) ? cfg_wait : wait_lat_q),
        .expired  (expired)
    );

    cs_beat_fsm #(.BEAT_W(BEAT_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cfg_valid    (cfg_valid),
        .cfg_auto_ack (cfg_auto_ack),
        .req_start    (req_start),
        .req_write    (req_write),
        .req_beats_m1 (req_beats_m1),
        .ack_q        (ack_q),
        .expired      (expired),
        .state        (state),
        .mode         (mode),
        .beat_end     (beat_end),
        .last_beat    (last_beat),
        .timer_load   (timer_load)
    );

    assign cs_n      = ~in_beat;
    assign wr_oe     = mode.write & (in_beat | (state == ST_TAIL));
    assign rd_latch  = beat_end & ~mode.write;
    assign beat_done = beat_end;
    assign xfer_done = beat_end & last_beat;

    // R5: chip select released the cycle after the final beat
    p_cs_release_r5: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> cs_n);

    // R5: chip select held between beats of one transfer
    p_cs_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (beat_done && !xfer_done) |=> !cs_n);

    // R6: write data stays driven one cycle past chip-select release
    p_wr_tail_r6: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && wr_oe) |=> (wr_oe && cs_n));

    // R4: read strobe only at the end of a read beat
    p_rd_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        rd_latch |-> (beat_done && !wr_oe && !cs_n));

    // R8: an invalid window never opens
    p_invalid_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (cs_n && !wr_oe && !cfg_valid) |=> cs_n);

    // R10: transfer completion coincides with a beat completion
    p_xfer_beat_r10: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> beat_done);

endmodule

// File: tb/cs_term_ctrl_tb_top.sv
`timescale 1ns/1ps
module cs_term_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_valid, cfg_auto_ack, req_start, req_write, ext_ack;
    logic [3:0] cfg_wait, req_beats_m1;
    logic       cs_n, rd_latch, wr_oe, beat_done, xfer_done;

    int checks = 0;
    int errors = 0;
    int kk[16];
    int hh[16];

    always #2 clk = ~clk;

    cs_term_ctrl #(.WAIT_W(4), .BEAT_W(4)) dut_i (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_auto_ack(cfg_auto_ack),
        .cfg_wait(cfg_wait), .req_start(req_start), .req_write(req_write),
        .req_beats_m1(req_beats_m1), .ext_ack(ext_ack), .cs_n(cs_n),
        .rd_latch(rd_latch), .wr_oe(wr_oe), .beat_done(beat_done), .xfer_done(xfer_done)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected end cycle of a beat from R1/R2/R3
    function automatic int exp_end(input bit au, input int w, input int k);
        if (!au) return k + 1;
        if (k < 0) return w;
        return (k + 1 < w) ? k + 1 : w;
    endfunction

    task automatic run_xfer(input bit au, input int w, input bit wr, input int nb,
                            input bit pre_ack, input string tg);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_auto_ack = au; cfg_wait = 4'(w);
        req_write = wr; req_beats_m1 = 4'(nb - 1); req_start = 1'b1;
        ext_ack = pre_ack;  // R7: high while cs_n is still high
        for (int b = 0; b < nb; b++) begin
            int e;
            string et;
            e = exp_end(au, w, kk[b]);
            if (!au) et = "R1";
            else if (kk[b] >= 0 && kk[b] + 1 < w) et = "R3";
            else et = "R2";
            for (int c = 0; c <= e; c++) begin
                bit endc;
                @(negedge clk);
                req_start = 1'b0;
                cfg_wait = 4'($urandom);        // R9: must not matter once latched
                cfg_auto_ack = 1'($urandom);
                endc = (c == e);
                chk($sformatf("%s%s beat_done b%0d c%0d %s", et, (au && b > 0) ? " R9" : "", b, c, tg),
                    beat_done, endc);
                chk($sformatf("R5 cs_n in beat %s", tg), cs_n, 1'b0);
                chk($sformatf("R6 wr_oe in beat %s", tg), wr_oe, wr);
                chk($sformatf("R4 rd_latch %s", tg), rd_latch, endc && !wr);
                chk($sformatf("R10 xfer_done %s", tg), xfer_done, endc && (b == nb - 1));
                ext_ack = (kk[b] >= 0 && c >= kk[b] && c < kk[b] + hh[b]);
            end
        end
        @(negedge clk);
        ext_ack = 1'b0;
        chk($sformatf("R5 cs_n released %s", tg), cs_n, 1'b1);
        chk($sformatf("R6 wr_oe tail %s", tg), wr_oe, wr);
        chk($sformatf("R10 no extra beat %s", tg), beat_done, 1'b0);
        @(negedge clk);
        chk($sformatf("R6 wr_oe off %s", tg), wr_oe, 1'b0);
        chk($sformatf("R5 cs_n idle %s", tg), cs_n, 1'b1);
    endtask

    task automatic main_flow();
        void'($urandom(32'd20250611));
        rst = 1'b1; cfg_valid = 0; cfg_auto_ack = 0; cfg_wait = 0;
        req_start = 0; req_write = 0; req_beats_m1 = 0; ext_ack = 0;
        repeat (3) @(negedge clk);
        chk("R11 cs_n reset", cs_n, 1'b1);
        chk("R11 rd_latch reset", rd_latch, 1'b0);
        chk("R11 wr_oe reset", wr_oe, 1'b0);
        chk("R11 beat_done reset", beat_done, 1'b0);
        chk("R11 xfer_done reset", xfer_done, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        // R8: request with window invalid
        cfg_valid = 1'b0; cfg_auto_ack = 1'b1; cfg_wait = 4'd0; req_start = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            req_start = (i < 2);
            chk("R8 cs_n stays high", cs_n, 1'b1);
            chk("R8 no beat", beat_done, 1'b0);
        end
        req_start = 1'b0;

        // Directed: wait 0, wait 15, tie of expiry and external ack
        kk[0] = -1; hh[0] = 1; kk[1] = -1; hh[1] = 1;
        run_xfer(1'b1, 0, 1'b0, 2, 1'b0, "w0");
        run_xfer(1'b1, 15, 1'b1, 1, 1'b0, "w15");
        kk[0] = 3; hh[0] = 1; kk[1] = -1; hh[1] = 1;
        run_xfer(1'b1, 4, 1'b0, 2, 1'b0, "tie");
        // R7: ack held into end cycle must not end next beat early
        kk[0] = 1; hh[0] = 2; kk[1] = -1; hh[1] = 1;
        run_xfer(1'b1, 3, 1'b1, 2, 1'b0, "R7 held");
        // R7: ack high before chip select low is ignored
        kk[0] = -1; hh[0] = 1;
        run_xfer(1'b1, 3, 1'b0, 1, 1'b1, "R7 pre");
        // Long non-auto burst
        for (int b = 0; b < 16; b++) begin kk[b] = b % 3; hh[b] = 1 + (b % 2); end
        run_xfer(1'b0, 2, 1'b1, 16, 1'b0, "burst16");

        // Constrained random
        for (int t = 0; t < 200; t++) begin
            bit au, wr;
            int w, nb;
            au = 1'($urandom_range(0, 1));
            wr = 1'($urandom_range(0, 1));
            w  = $urandom_range(0, 5);
            nb = $urandom_range(1, 4);
            for (int b = 0; b < nb; b++) begin
                if (au) kk[b] = (w > 0 && $urandom_range(0, 1) == 1) ? $urandom_range(0, w - 1) : -1;
                else    kk[b] = $urandom_range(0, 6);
                hh[b] = $urandom_range(1, 2);
            end
            run_xfer(au, w, wr, nb, 1'($urandom_range(0, 1)), "rand");
        end
    endtask

    initial begin
        fork
            main_flow();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule